// File: doc/BRIEF.md
# SPI Register-Access Slave

This block lets an external SPI master read and write a 16-bit-addressed space of 16-bit registers. A transaction opens when chip select falls. The master then sends an 8-bit command and a 16-bit address, followed by any number of 16-bit data words. The register address moves on by one after each word for as long as chip select stays low. Every field travels most significant bit first. SCLK idles low.

A read does not start with the register contents. The slave first returns a 16-bit check word built from the command byte and the upper address byte. A master that gets back all zeros or all ones can tell that no slave is answering. While chip select is high, MISO is always driven. It shows whether the core is halted.

The block samples all SPI pins with the system clock. It talks to the register space through a plain strobe port. Every write or read strobe is accepted in the cycle it is raised, so there is no back-pressure. Read data must be valid in the cycle after the read strobe.

Top module: `spi_regslv`

## Requirements
- R1: Command byte 0x02 selects a write. The first 16 data bits after the address cause one `mem_wr_en` pulse, with `mem_addr` equal to the received address and `mem_wdata` equal to the received word.
- R2: During a write with chip select held low, each further complete 16-bit word is written to the previous address plus one. The address wraps from 0xFFFF to 0x0000.
- R3: Command byte 0x03 selects a read. The 16 MISO bits after the address carry the check word {command, address[15:8]}. The next 16 bits carry the contents of the addressed register.
- R4: During a read with chip select held low, each further 16 clocks return the register at the previous address plus one, wrapping from 0xFFFF to 0x0000.
- R5: MOSI is sampled on SCLK rising edges. MISO changes only while SCLK is low, so it is stable around every rising edge.
- R6: While chip select is high, MISO equals `core_halted` (0 when running, 1 when halted). This includes the state after reset.
- R7: A data word cut short by chip select rising before its 16th bit is discarded. It causes no write.
- R8: A command other than 0x02 or 0x03 causes no write strobe and no read strobe. MISO stays 0 for the rest of that transaction.
- R9: At most one of `mem_wr_en` and `mem_rd_en` is high in any cycle. A read of address A first strobes `mem_rd_en` with `mem_addr` = A. Neither strobe fires while chip select is high.
- R10: Raising chip select in the command or address phase abandons the transaction with no strobe. The next transaction starts again from the command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI pins are sampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from the master, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master; halt status when deselected |
| core_halted | input | 1 | 1 while the core is stopped |
| mem_addr | output | 16 | Register address for the current strobe |
| mem_wdata | output | 16 | Write data, valid with `mem_wr_en` |
| mem_wr_en | output | 1 | One-cycle write strobe |
| mem_rd_en | output | 1 | One-cycle read strobe |
| mem_rdata | input | 16 | Read data, valid in the cycle after `mem_rd_en` |

## Verification
The assertions take for granted that SCLK idles low and that each SCLK phase lasts at least SYNC_STAGES+2 system clocks. They also assume that chip select changes only while SCLK is low, well away from an SCLK edge. Under these conditions every SCLK edge is seen once, and strobes never run past the point where chip select returns high. The bench drives all pins on the falling edge of the system clock, holds each SCLK phase for eight clocks, and waits half an SCLK period before and after each chip-select change. Its memory model answers every read in the following cycle.

// File: rtl/spi_regslv_pkg.sv
package spi_regslv_pkg;
  localparam logic [7:0] CMD_WRITE = 8'h02;
  localparam logic [7:0] CMD_READ  = 8'h03;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_WR,
    PH_RD,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/spi_regslv_sync.sv
// Multi-stage synchronizer, one chain per bit, with a per-bit reset value.
module spi_regslv_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {STAGES{RST_VAL[i]}};
      else        ff <= {ff[STAGES-2:0], d[i]};
    end
    assign q[i] = ff[STAGES-1];
  end
endmodule

// File: rtl/spi_regslv_ctrl.sv
// Receive side: field framing on SCLK rising edges, address pointer,
// register-port strobes and the next word to send on a read.
module spi_regslv_ctrl
  import spi_regslv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CMD_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_rise,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wr_en,
  output logic              mem_rd_en,
  output logic              word_vld,
  output logic [DATA_W-1:0] word
);
  localparam int SH_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W = $clog2(SH_W);
  localparam int CHK_W = DATA_W - CMD_W;

  phase_e            ph;
  logic [SH_W-1:0]   sh;
  logic [SH_W-1:0]   nxt;
  logic [CNT_W-1:0]  bidx;
  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] ptr;
  logic              rd_pend;
  logic [DATA_W-1:0] hold;

  assign nxt = {sh[SH_W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_CMD;
      sh        <= '0;
      bidx      <= '0;
      cmd_q     <= '0;
      ptr       <= '0;
      rd_pend   <= 1'b0;
      hold      <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_wr_en <= 1'b0;
      mem_rd_en <= 1'b0;
      word_vld  <= 1'b0;
      word      <= '0;
    end else begin
      mem_wr_en <= 1'b0;
      mem_rd_en <= 1'b0;
      word_vld  <= 1'b0;
      // fixed one-cycle read latency: capture the cycle after the strobe
      rd_pend   <= mem_rd_en;
      if (rd_pend) hold <= mem_rdata;

      if (cs_n_s) begin
        ph   <= PH_CMD;
        bidx <= '0;
      end else if (sclk_rise) begin
        sh   <= nxt;
        bidx <= bidx + 1'b1;
        unique case (ph)
          PH_CMD: begin
            if (bidx == CNT_W'(CMD_W-1)) begin
              cmd_q <= nxt[CMD_W-1:0];
              ph    <= PH_ADDR;
              bidx  <= '0;
            end
          end
          PH_ADDR: begin
            if (bidx == CNT_W'(ADDR_W-1)) begin
              bidx <= '0;
              if (cmd_q == CMD_W'(CMD_WRITE)) begin
                ph  <= PH_WR;
                ptr <= nxt[ADDR_W-1:0];
              end else if (cmd_q == CMD_W'(CMD_READ)) begin
                ph        <= PH_RD;
                mem_addr  <= nxt[ADDR_W-1:0];
                mem_rd_en <= 1'b1;
                ptr       <= nxt[ADDR_W-1:0] + ADDR_W'(1);
                word      <= {cmd_q, nxt[ADDR_W-1 -: CHK_W]};
                word_vld  <= 1'b1;
              end else begin
                ph <= PH_SKIP;
              end
            end
          end
          PH_WR: begin
            if (bidx == CNT_W'(DATA_W-1)) begin
              bidx      <= '0;
              mem_addr  <= ptr;
              mem_wdata <= nxt[DATA_W-1:0];
              mem_wr_en <= 1'b1;
              ptr       <= ptr + ADDR_W'(1);
            end
          end
          PH_RD: begin
            if (bidx == CNT_W'(DATA_W-1)) begin
              bidx      <= '0;
              word      <= hold;
              word_vld  <= 1'b1;
              mem_addr  <= ptr;
              mem_rd_en <= 1'b1;
              ptr       <= ptr + ADDR_W'(1);
            end
          end
          default: bidx <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_regslv_tx.sv
// Transmit side: word load and shift on SCLK falling edges, MISO register.
module spi_regslv_tx #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_fall,
  input  logic              word_vld,
  input  logic [DATA_W-1:0] word,
  input  logic              halted,
  output logic              miso
);
  logic              pend;
  logic              active;
  logic [DATA_W-1:0] nxt_w;
  logic [DATA_W-1:0] tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      active <= 1'b0;
      nxt_w  <= '0;
      tx     <= '0;
      miso   <= 1'b0;
    end else begin
      if (cs_n_s) begin
        pend   <= 1'b0;
        active <= 1'b0;
      end else if (word_vld) begin
        pend  <= 1'b1;
        nxt_w <= word;
      end else if (sclk_fall) begin
        if (pend) begin
          tx     <= nxt_w;
          pend   <= 1'b0;
          active <= 1'b1;
        end else begin
          tx <= {tx[DATA_W-2:0], 1'b0};
        end
      end
      miso <= cs_n_s ? halted : (active & tx[DATA_W-1]);
    end
  end
endmodule

// File: rtl/spi_regslv.sv
module spi_regslv #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int CMD_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              core_halted,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wr_en,
  output logic              mem_rd_en,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic       sclk_s, cs_n_s, mosi_s, sclk_d;
  logic       sclk_rise, sclk_fall;
  logic       word_vld;
  logic [DATA_W-1:0] word;

  // bit order {mosi, cs_n, sclk}; chip select resets to deselected
  spi_regslv_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_mosi, spi_cs_n, spi_sclk}),
    .q     ({mosi_s, cs_n_s, sclk_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;

  spi_regslv_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_s    (cs_n_s),
    .sclk_rise (sclk_rise),
    .mosi_s    (mosi_s),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_wr_en (mem_wr_en),
    .mem_rd_en (mem_rd_en),
    .word_vld  (word_vld),
    .word      (word)
  );

  spi_regslv_tx #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_s    (cs_n_s),
    .sclk_fall (sclk_fall),
    .word_vld  (word_vld),
    .word      (word),
    .halted    (core_halted),
    .miso      (spi_miso)
  );
endmodule

// File: rtl/spi_regslv_chk.sv
module spi_regslv_chk #(
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic              spi_miso,
  input logic              core_halted,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_wr_en,
  input logic              mem_rd_en
);
  localparam int SETTLE = SYNC_STAGES + 2;
  localparam int HC_W   = $clog2(SETTLE + 1) + 1;

  logic [HC_W-1:0]   hi_cnt;
  logic              settled;
  logic              wr_seen, rd_seen;
  logic [ADDR_W-1:0] wr_last, rd_last;

  assign settled = (hi_cnt == HC_W'(SETTLE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt  <= '0;
      wr_seen <= 1'b0;
      rd_seen <= 1'b0;
      wr_last <= '0;
      rd_last <= '0;
    end else begin
      if (!spi_cs_n)    hi_cnt <= '0;
      else if (!settled) hi_cnt <= hi_cnt + 1'b1;
      if (spi_cs_n) begin
        wr_seen <= 1'b0;
        rd_seen <= 1'b0;
      end else begin
        if (mem_wr_en) begin wr_seen <= 1'b1; wr_last <= mem_addr; end
        if (mem_rd_en) begin rd_seen <= 1'b1; rd_last <= mem_addr; end
      end
    end
  end

  a_r6_desel_status: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> spi_miso == $past(core_halted));

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_en && mem_rd_en));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> (!mem_wr_en && !mem_rd_en));

  a_r2_wr_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && wr_seen) |-> mem_addr == ADDR_W'(wr_last + ADDR_W'(1)));

  a_r4_rd_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && rd_seen) |-> mem_addr == ADDR_W'(rd_last + ADDR_W'(1)));

  a_r1_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> !mem_wr_en);
endmodule

bind spi_regslv spi_regslv_chk #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_cs_n    (spi_cs_n),
  .spi_miso    (spi_miso),
  .core_halted (core_halted),
  .mem_addr    (mem_addr),
  .mem_wr_en   (mem_wr_en),
  .mem_rd_en   (mem_rd_en)
);

// File: tb/sim_spi_regslv.sv
module sim_spi_regslv;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic        clk = 1'b0;
  logic        rst_n, spi_sclk, spi_cs_n, spi_mosi, spi_miso, core_halted;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_wr_en, mem_rd_en;

  logic        pl_en;
  logic [7:0]  pl_addr;
  logic [15:0] pl_data;
  logic [15:0] mem [256];
  int          wr_cnt, rd_cnt, both_cnt, r5_viol;
  logic [15:0] wr_log [64];
  logic [15:0] rd_log [64];
  logic        prev_miso;
  int          n_chk, n_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regslv u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .core_halted(core_halted),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wr_en(mem_wr_en),
    .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata)
  );

  // register-space model (one-cycle read latency) and strobe monitor
  always @(posedge clk) begin
    if (pl_en) mem[pl_addr] <= pl_data;
    if (mem_wr_en) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_log[wr_cnt % 64] <= mem_addr;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_rd_en) begin
      mem_rdata <= mem[mem_addr[7:0]];
      rd_log[rd_cnt % 64] <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end
    if (mem_wr_en && mem_rd_en) both_cnt <= both_cnt + 1;
  end

  // R5 monitor: MISO must not move while SCLK is high in a transaction
  always @(negedge clk) begin
    if (rst_n && !spi_cs_n && spi_sclk && spi_miso !== prev_miso) r5_viol <= r5_viol + 1;
    prev_miso <= spi_miso;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); pl_en = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk); pl_en = 1'b0;
  endtask

  task automatic spi_bit(input logic b, output logic r);
    spi_mosi = b;
    repeat (HALF) @(negedge clk);
    r = spi_miso;
    spi_sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_sclk = 1'b0;
  endtask

  task automatic spi_field(input int nb, input logic [15:0] w, output logic [15:0] r);
    logic b;
    r = '0;
    for (int i = nb - 1; i >= 0; i--) begin
      spi_bit(w[i], b);
      r = {r[14:0], b};
    end
  endtask

  task automatic cs_open();
    @(negedge clk); spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_close();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (10) @(negedge clk);
    chk("R6 miso after reset", {31'd0, spi_miso}, 32'd0);
    chk("R9 no strobes after reset", wr_cnt + rd_cnt, 32'd0);
  endtask

  task automatic t_write_single();
    logic [15:0] r;
    int w0 = wr_cnt;
    cs_open();
    spi_field(8, 16'h0002, r);
    spi_field(16, 16'h1234, r);
    spi_field(16, 16'hA5C3, r);
    cs_close();
    chk("R1 write count", wr_cnt - w0, 32'd1);
    chk("R1 write address", {16'd0, wr_log[w0 % 64]}, 32'h1234);
    chk("R1 written data", {16'd0, mem[8'h34]}, 32'hA5C3);
  endtask

  task automatic t_write_burst();
    logic [15:0] r;
    int w0 = wr_cnt;
    cs_open();
    spi_field(8, 16'h0002, r);
    spi_field(16, 16'h0040, r);
    spi_field(16, 16'h1111, r);
    spi_field(16, 16'h2222, r);
    spi_field(16, 16'h3333, r);
    cs_close();
    chk("R2 burst count", wr_cnt - w0, 32'd3);
    chk("R2 burst word 0", {16'd0, mem[8'h40]}, 32'h1111);
    chk("R2 burst word 1", {16'd0, mem[8'h41]}, 32'h2222);
    chk("R2 burst word 2", {16'd0, mem[8'h42]}, 32'h3333);
  endtask

  task automatic t_write_wrap();
    logic [15:0] r;
    int w0 = wr_cnt;
    cs_open();
    spi_field(8, 16'h0002, r);
    spi_field(16, 16'hFFFF, r);
    spi_field(16, 16'hBEEF, r);
    spi_field(16, 16'hCAFE, r);
    cs_close();
    chk("R2 wrap first addr", {16'd0, wr_log[w0 % 64]}, 32'hFFFF);
    chk("R2 wrap second addr", {16'd0, wr_log[(w0 + 1) % 64]}, 32'h0000);
    chk("R2 wrap data", {mem[8'hFF], mem[8'h00]}, 32'hBEEFCAFE);
  endtask

  task automatic t_read_single();
    logic [15:0] r;
    int r0 = rd_cnt;
    preload(8'h56, 16'h9A7C);
    cs_open();
    spi_field(8, 16'h0003, r);
    spi_field(16, 16'h1256, r);
    spi_field(16, 16'h0000, r);
    chk("R3 check word", {16'd0, r}, 32'h0312);
    spi_field(16, 16'h0000, r);
    chk("R3 read data", {16'd0, r}, 32'h9A7C);
    cs_close();
    chk("R9 first read address", {16'd0, rd_log[r0 % 64]}, 32'h1256);
  endtask

  task automatic t_read_burst();
    logic [15:0] r;
    preload(8'hFE, 16'h0101);
    preload(8'hFF, 16'h0202);
    preload(8'h00, 16'h0303);
    cs_open();
    spi_field(8, 16'h0003, r);
    spi_field(16, 16'hFFFE, r);
    spi_field(16, 16'h0000, r);
    chk("R3 check word burst", {16'd0, r}, 32'h03FF);
    spi_field(16, 16'h0000, r);
    chk("R4 burst word 0", {16'd0, r}, 32'h0101);
    spi_field(16, 16'h0000, r);
    chk("R4 burst word 1", {16'd0, r}, 32'h0202);
    spi_field(16, 16'h0000, r);
    chk("R4 burst word 2 wrapped", {16'd0, r}, 32'h0303);
    cs_close();
  endtask

  task automatic t_truncated();
    logic [15:0] r;
    int w0 = wr_cnt;
    preload(8'h11, 16'h5555);
    cs_open();
    spi_field(8, 16'h0002, r);
    spi_field(16, 16'h0010, r);
    spi_field(16, 16'h4444, r);
    spi_field(9, 16'h01FF, r);
    cs_close();
    chk("R7 only full word written", wr_cnt - w0, 32'd1);
    chk("R7 partial word dropped", {16'd0, mem[8'h11]}, 32'h5555);
  endtask

  task automatic t_bad_cmd();
    logic [15:0] r;
    logic [15:0] acc;
    int w0 = wr_cnt;
    int r0 = rd_cnt;
    preload(8'h20, 16'h7777);
    cs_open();
    spi_field(8, 16'h0005, r);
    acc = r;
    spi_field(16, 16'h0020, r);
    acc = acc | r;
    spi_field(16, 16'hFFFF, r);
    acc = acc | r;
    spi_field(16, 16'hFFFF, r);
    acc = acc | r;
    cs_close();
    chk("R8 miso low for unknown command", {16'd0, acc}, 32'd0);
    chk("R8 no strobes for unknown command", (wr_cnt - w0) + (rd_cnt - r0), 32'd0);
    chk("R8 register untouched", {16'd0, mem[8'h20]}, 32'h7777);
  endtask

  task automatic t_abort();
    logic [15:0] r;
    int w0 = wr_cnt;
    int r0 = rd_cnt;
    cs_open();
    spi_field(8, 16'h0002, r);
    spi_field(12, 16'h0ABC, r);
    cs_close();
    chk("R10 cut address gives no strobe", (wr_cnt - w0) + (rd_cnt - r0), 32'd0);
    preload(8'h77, 16'hD00D);
    cs_open();
    spi_field(8, 16'h0003, r);
    spi_field(16, 16'h4477, r);
    spi_field(16, 16'h0000, r);
    chk("R10 next transaction check word", {16'd0, r}, 32'h0344);
    spi_field(16, 16'h0000, r);
    chk("R10 next transaction data", {16'd0, r}, 32'hD00D);
    cs_close();
  endtask

  task automatic t_halted();
    @(negedge clk); core_halted = 1'b1;
    repeat (6) @(negedge clk);
    chk("R6 miso shows halted", {31'd0, spi_miso}, 32'd1);
    core_halted = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6 miso shows running", {31'd0, spi_miso}, 32'd0);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0;
    wr_cnt = 0; rd_cnt = 0; both_cnt = 0; r5_viol = 0;
    prev_miso = 1'b0;
    rst_n = 1'b0; spi_sclk = 1'b0; spi_cs_n = 1'b1; spi_mosi = 1'b0;
    core_halted = 1'b0; pl_en = 1'b0; pl_addr = '0; pl_data = '0;
    mem_rdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_single();
    t_write_burst();
    t_write_wrap();
    t_read_single();
    t_read_burst();
    t_truncated();
    t_bad_cmd();
    t_abort();
    t_halted();
    chk("R5 miso stable while sclk high", r5_viol, 32'd0);
    chk("R9 never both strobes", both_cnt, 32'd0);
    finish_run();
  end
endmodule